// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog timer for a real-time-clock companion chip. A single control byte sets the timeout: a 5-bit multiplier in bits 6:2 is scaled by four raised to the 2-bit resolution field in bits 1:0. The countdown runs on a 16 Hz tick, so one unit is one sixteenth of a second. Software keeps the watchdog alive by writing the control byte or by reading it. Either access reloads the countdown and clears the expiry flag.

When the countdown runs out, bit 7 of the control byte chooses what happens. If it is set, the block requests a system reset, zeroes the control byte and clears bit 6 of a day register. If it is clear, the block gives one interrupt pulse and leaves the control byte and the day register alone. In both cases bit 7 of a read-only flags register is set.

A three-state machine runs the block:
- WD_IDLE: disarmed.
- WD_ARMED: counting down.
- WD_FIRE: a single cycle in which the expiry action is taken.

The transitions are:
- restart-armed: any state goes to WD_ARMED when the control byte is accessed and its span is nonzero.
- restart-disarm: any state goes to WD_IDLE when the control byte is accessed and its span is zero.
- expire: WD_ARMED goes to WD_FIRE when the last tick of the span arrives.
- retire: WD_FIRE always goes to WD_IDLE, unless a restart arrives in the same cycle.

Top module: `wdog_steer`

## Requirements
- R1: The register select picks the register: 0 is the control byte, 1 is the flags register, 2 is the day register and 3 reads as zero. The timeout, in ticks, is bits 6:2 times 4^(bits 1:0) of the control byte. The expiry action fires in the cycle after the edge that sampled the last tick of that span.
- R2: A control value whose span is zero disables the watchdog. This covers a value of 0, and also any value with a zero multiplier and a nonzero resolution field. A disabled watchdog never expires.
- R3: Writing the control byte stores the written value, clears the flag and restarts the countdown.
- R4: Reading the control byte returns the stored value, clears the flag and restarts the countdown with the stored value.
- R5: On expiry, bit 7 of the flags register becomes 1. All other bits of the flags register read 0.
- R6: On expiry with control bit 7 set, the block does three things:
  - wd_reset_req is high for exactly one cycle and wd_irq stays low.
  - The control byte becomes 0.
  - Bit 6 of the day register becomes 0.
- R7: On expiry with control bit 7 clear, the block does three things:
  - wd_irq is high for exactly one cycle and wd_reset_req stays low.
  - The control byte keeps its value.
  - The day register is unchanged.
- R8: Writes to the flags register are ignored.
- R9: After an expiry, the block raises no further expiry until the control byte is accessed again.
- R10: The countdown advances only on cycles where tick_16 is high. Without ticks, no expiry occurs however many cycles pass.
- R11: After reset, the control byte, the flags register and the day register all read 0, and both outputs are low.
- R12: The day register stores only bit 6 of a write. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16 | input | 1 | One-cycle pulse at 16 Hz |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 flags, 2 day |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| wd_reset_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with the package defaults: a 5-bit multiplier and a 2-bit resolution field, which gives an 11-bit counter and spans of up to 1984 ticks. With these widths, every resolution scale up to 64 is run to expiry, along with both steering choices. The zero-multiplier disable encodings are also within reach. Keep-alive by read, and the no-rearm behaviour after expiry, are exercised in cycle counts the run can afford.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W   = 8;
    localparam int MULT_W   = 5;
    localparam int RES_W    = 2;
    localparam int SEL_W    = 2;
    localparam int STEER_B  = 7;
    localparam int FLAG_B   = 7;
    localparam int DAYCLR_B = 6;
    localparam int MAX_SH   = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W    = MULT_W + MAX_SH;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_FLAGS = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DAY   = 2'd2;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_e;

    function automatic logic [CNT_W-1:0] wd_span(input logic [DATA_W-1:0] v);
        logic [CNT_W-1:0] m;
        m = CNT_W'(v[RES_W +: MULT_W]);
        return m << (2 * v[RES_W-1:0]);
    endfunction
endpackage

// File: rtl/wdog_span_ctr.sv
module wdog_span_ctr
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             run,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && tick && !load && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic span_nz,
    input  logic expire,
    input  logic steer,
    output logic run,
    output logic fire,
    output logic rst_req,
    output logic irq
);
    wd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = span_nz ? WD_ARMED : WD_IDLE;
        end else begin
            unique case (state_q)
                WD_IDLE:  state_d = WD_IDLE;
                WD_ARMED: state_d = expire ? WD_FIRE : WD_ARMED;
                WD_FIRE:  state_d = WD_IDLE;
                default:  state_d = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run     = (state_q == WD_ARMED);
        fire    = (state_q == WD_FIRE);
        rst_req = fire && steer;
        irq     = fire && !steer;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fire,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              flag_q,
    output logic              day_q,
    output logic              restart,
    output logic [DATA_W-1:0] new_val
);
    logic hit_ctrl, steer_fire;

    assign hit_ctrl   = (sel == SEL_CTRL);
    assign restart    = (wr || rd) && hit_ctrl;
    assign new_val    = wr ? wdata : ctrl_q;
    assign steer_fire = fire && ctrl_q[STEER_B];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
            day_q  <= 1'b0;
        end else begin
            if (wr && hit_ctrl)  ctrl_q <= wdata;
            else if (steer_fire) ctrl_q <= '0;

            if (restart)   flag_q <= 1'b0;
            else if (fire) flag_q <= 1'b1;

            if (wr && sel == SEL_DAY) day_q <= wdata[DAYCLR_B];
            else if (steer_fire)      day_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL:  rdata = ctrl_q;
            SEL_FLAGS: rdata[FLAG_B] = flag_q;
            SEL_DAY:   rdata[DAYCLR_B] = day_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wd_reset_req,
    output logic              wd_irq
);
    logic [DATA_W-1:0] ctrl_q, new_val;
    logic              flag_q, day_q, restart;
    logic              run, fire, expire;
    logic [CNT_W-1:0]  span;

    assign span = wd_span(new_val);

    wdog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .sel(reg_sel),
        .wdata(reg_wdata), .fire(fire), .rdata(reg_rdata), .ctrl_q(ctrl_q),
        .flag_q(flag_q), .day_q(day_q), .restart(restart), .new_val(new_val)
    );

    wdog_span_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .load(restart), .load_val(span),
        .tick(tick_16), .run(run), .expire(expire)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .restart(restart), .span_nz(span != '0),
        .expire(expire), .steer(ctrl_q[STEER_B]), .run(run), .fire(fire),
        .rst_req(wd_reset_req), .irq(wd_irq)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [SEL_W-1:0]  sel,
    input logic              irq,
    input logic              rst_req,
    input logic              flag,
    input logic [DATA_W-1:0] ctrl,
    input logic              restart
);
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req)); // R6
    AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq || rst_req) && !restart) |=> flag); // R5
    AST_CTRL_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !(wr && sel == SEL_CTRL)) |=> (ctrl == '0)); // R6
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flag); // R3
    AST_FLAGS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_FLAGS && !irq && !rst_req && !restart) |=> $stable(flag)); // R8
endmodule

bind wdog_steer wdog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .irq(wd_irq),
    .rst_req(wd_reset_req), .flag(flag_q), .ctrl(ctrl_q), .restart(restart)
);

// File: tb/sim_wdog_steer.sv
module sim_wdog_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16 = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       wd_reset_req, wd_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdog_steer u0 (
        .clk(clk), .rst_n(rst_n), .tick_16(tick_16), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wd_reset_req(wd_reset_req), .wd_irq(wd_irq)
    );

    localparam int NV = 6;
    localparam logic [7:0] V_CTRL [NV] = '{8'h0C, 8'h09, 8'h06, 8'h07, 8'h88, 8'h8D};
    localparam int         V_TICK [NV] = '{3, 8, 16, 64, 2, 12};
    localparam bit         V_RST  [NV] = '{0, 0, 0, 0, 1, 1};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
        reg_rd = 1'b1; reg_sel = s;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick_16 = 1'b1;
            @(negedge clk);
            tick_16 = 1'b0;
            if (wd_irq || wd_reset_req) pulses++;
            @(negedge clk);
            if (wd_irq || wd_reset_req) pulses++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 outputs", {wd_irq, wd_reset_req}, 0);
        bus_rd(2'd0, d); chk("R11 ctrl", d, 0);
        bus_rd(2'd1, d); chk("R11 flags", d, 0);
        bus_rd(2'd2, d); chk("R11 day", d, 0);
        bus_rd(2'd3, d); chk("R1 sel3 reads zero", d, 0);
        // R12 day stores bit 6 only
        bus_wr(2'd2, 8'hFF); bus_rd(2'd2, d); chk("R12 day mask", d, 8'h40);

        // Vector table: span, steering, side effects (R1 R5 R6 R7)
        for (int v = 0; v < NV; v++) begin
            bus_wr(2'd2, 8'h40);
            bus_wr(2'd0, V_CTRL[v]);
            ticks(V_TICK[v] - 1, p);
            chk("R1 no early expiry", p, 0);
            bus_rd(2'd1, d); chk("R5 flag clear before expiry", d, 0);
            tick_16 = 1'b1; @(negedge clk); tick_16 = 1'b0;
            chk("R6 reset pulse", wd_reset_req, V_RST[v]);
            chk("R7 irq pulse", wd_irq, !V_RST[v]);
            @(negedge clk);
            chk("R6 R7 one cycle", {wd_irq, wd_reset_req}, 0);
            bus_rd(2'd1, d); chk("R5 flag set", d, 8'h80);
            bus_rd(2'd2, d); chk("R6 R7 day bit", d, V_RST[v] ? 8'h00 : 8'h40);
            bus_rd(2'd0, d); chk("R6 R7 ctrl after expiry", d, V_RST[v] ? 8'h00 : V_CTRL[v]);
        end

        // R9 no rearm after expiry without access
        bus_wr(2'd0, 8'h0C);
        ticks(3, p); chk("R9 first expiry", p, 1);
        ticks(20, p); chk("R9 no rearm", p, 0);
        // R8 flags write ignored (flag is 1)
        bus_wr(2'd1, 8'h00); bus_rd(2'd1, d); chk("R8 flags write ignored", d, 8'h80);
        // R3 write clears flag
        bus_wr(2'd0, 8'h10); bus_rd(2'd1, d); chk("R3 write clears flag", d, 0);
        bus_rd(2'd0, d); chk("R3 write stored", d, 8'h10);
        // R4 read restarts: span 4
        ticks(3, p);
        bus_rd(2'd0, d); chk("R4 read value", d, 8'h10);
        ticks(3, p); chk("R4 read restarted", p, 0);
        ticks(1, p); chk("R4 expiry after read", p, 1);
        bus_rd(2'd0, d);
        bus_rd(2'd1, d); chk("R4 read clears flag", d, 0);
        // R8 flags write of 1 ignored
        bus_wr(2'd1, 8'h80); bus_rd(2'd1, d); chk("R8 flags set ignored", d, 0);
        // R10 no ticks, no expiry
        bus_wr(2'd0, 8'h04);
        repeat (60) @(negedge clk);
        chk("R10 no tick no expiry", {wd_irq, wd_reset_req}, 0);
        bus_rd(2'd1, d); chk("R10 flag still clear", d, 0);
        // R2 disabled encodings
        bus_wr(2'd0, 8'h00); ticks(80, p); chk("R2 zero ctrl", p, 0);
        bus_wr(2'd0, 8'h03); ticks(80, p); chk("R2 zero multiplier", p, 0);
        bus_wr(2'd0, 8'h83); ticks(10, p); chk("R2 zero multiplier steered", p, 0);
        bus_rd(2'd1, d); chk("R2 flag clear", d, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule